// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a parameterized bank of hardware semaphores that several processor cores use for mutual exclusion. Every core reaches the bank through its own simple register port. Each port has a write strobe, a byte address and write data. Read data comes back combinationally from the current state. Each semaphore occupies one 32-bit word, and the word sits at byte offset four times the semaphore index.

To claim a semaphore, a core writes a word that has the lock flag (bit 31) set and its core identifier in bits 11:8. It then reads the word back. The claim succeeded only if the read value equals exactly the word it wrote, keeping just the flag and the identifier. To free the semaphore, the owning core writes its identifier with bit 31 clear.

Writes from other cores cannot take or free a held semaphore. When several ports request the same free semaphore in one cycle, a fixed priority picks exactly one of them.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free, and every in-range address reads 0x0000_0000.
- R2: A write with bit 31 set to a free semaphore takes it. From the next cycle on, that word reads 0x8000_0000 with the writer's identifier in bits 11:8.
- R3: A lock write to a semaphore held by a different identifier is ignored, and the word keeps reading the current owner.
- R4: A write with bit 31 clear whose bits 11:8 equal the owner's identifier frees the semaphore. From the next cycle on, the word reads zero.
- R5: A write with bit 31 clear whose identifier differs from the owner's is ignored.
- R6: When several ports write lock requests to the same free semaphore in one cycle, the lowest-numbered port wins and is the only owner.
- R7: The bank decodes word index = address bits [ADDR_W-1:2]. A write to an index at or above the semaphore count is ignored, and a read there returns zero.
- R8: A write to one semaphore leaves every other semaphore unchanged.
- R9: Every bit other than bit 31 and bits 11:8 reads zero, whatever bits the lock write carried.
- R10: A lock write by the current owner leaves the semaphore held by that owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | NUM_PORTS | Write strobe per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port; port p uses slice [p*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_PORTS*32 | Write data per port |
| bus_rdata | output | NUM_PORTS*32 | Combinational read data per port |

## Verification
Directed patterns each isolate one rule: a foreign lock against a held word (R3), a foreign release (R5), a relock by the owner (R10), and a release by the owner (R4). Same-cycle contention for one word shows whether priority goes to the low port. Split contention, with the ports on different words, shows whether the ports stay independent. Lock words that carry garbage bits, and addresses past the last semaphore, separate proper field decode from plain storage of the word. A long randomized phase packs addresses into a few words, with some out of range, and compares every port's read data on every clock against a behavioural model.

// File: rtl/sem_pkg.sv
package sem_pkg;
   localparam int DATA_W   = 32;
   localparam int LOCK_BIT = 31;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 32,
   parameter int ADDR_W  = 10,
   parameter int ID_LSB  = 8,
   parameter int ID_W    = 4
) (
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [sem_pkg::DATA_W-1:0] wdata,
   output logic [NUM_SEM-1:0]        hit,
   output logic                      is_lock,
   output logic [ID_W-1:0]           id,
   output logic                      in_range,
   output logic [ADDR_W-3:0]         index
);
   assign index    = addr[ADDR_W-1:2];
   assign in_range = (int'(index) < NUM_SEM);
   assign is_lock  = wdata[sem_pkg::LOCK_BIT];
   assign id       = wdata[ID_LSB +: ID_W];

   for (genvar k = 0; k < NUM_SEM; k++) begin : g_hit
      assign hit[k] = we && (int'(index) == k);
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
   parameter int NUM_PORTS = 2,
   parameter int ID_W      = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PORTS-1:0]      hit,
   input  logic [NUM_PORTS-1:0]      lock,
   input  logic [NUM_PORTS*ID_W-1:0] id,
   output logic                      held,
   output logic [ID_W-1:0]           owner
);
   logic [NUM_PORTS-1:0] grant;
   logic                 any_grant;
   logic                 rel_ok;
   logic [ID_W-1:0]      new_id;

   always_comb begin
      grant     = '0;
      any_grant = 1'b0;
      new_id    = '0;
      rel_ok    = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (hit[p] && !lock[p] && (id[p*ID_W +: ID_W] == owner)) rel_ok = 1'b1;
         if (!any_grant && hit[p] && lock[p]) begin
            grant[p]  = 1'b1;
            any_grant = 1'b1;
            new_id    = id[p*ID_W +: ID_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held  <= 1'b0;
         owner <= '0;
      end else if (held) begin
         if (rel_ok) begin
            held  <= 1'b0;
            owner <= '0;
         end
      end else if (any_grant) begin
         held  <= 1'b1;
         owner <= new_id;
      end
   end

   a_r1_free_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !held);
   a_r2_take_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> $past(|(hit & lock)));
   a_r4_free_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held) |-> $past(|(hit & ~lock)));
   a_r3_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> $stable(owner));
   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM   = 32,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 10,
   parameter int ID_LSB    = 8,
   parameter int ID_W      = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS-1:0]                 bus_we,
   input  logic [NUM_PORTS*ADDR_W-1:0]          bus_addr,
   input  logic [NUM_PORTS*sem_pkg::DATA_W-1:0] bus_wdata,
   output logic [NUM_PORTS*sem_pkg::DATA_W-1:0] bus_rdata
);
   localparam int DW = sem_pkg::DATA_W;
   localparam int IW = ADDR_W - 2;
   localparam logic [DW-1:0] LIVE_MASK =
      (DW'(1) << sem_pkg::LOCK_BIT) | (((DW'(1) << ID_W) - DW'(1)) << ID_LSB);

   if (NUM_SEM * 4 > (1 << ADDR_W)) begin : g_bad_window
      $error("sem_bank: address window too small for NUM_SEM");
   end
   if (ID_LSB + ID_W > sem_pkg::LOCK_BIT) begin : g_bad_id
      $error("sem_bank: identifier field overlaps lock flag");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("sem_bank: need at least one port");
   end

   logic [NUM_SEM-1:0]   hit_pk  [NUM_PORTS];
   logic [NUM_PORTS-1:0] lock_v;
   logic [NUM_PORTS*ID_W-1:0] id_v;
   logic [NUM_PORTS-1:0] in_rng;
   logic [IW-1:0]        idx     [NUM_PORTS];
   logic [NUM_SEM-1:0]   held;
   logic [ID_W-1:0]      owner   [NUM_SEM];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      sem_port_dec #(
         .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .ID_LSB(ID_LSB), .ID_W(ID_W)
      ) i_dec (
         .we       (bus_we[p]),
         .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
         .wdata    (bus_wdata[p*DW +: DW]),
         .hit      (hit_pk[p]),
         .is_lock  (lock_v[p]),
         .id       (id_v[p*ID_W +: ID_W]),
         .in_range (in_rng[p]),
         .index    (idx[p])
      );

      logic [DW-1:0] word;
      always_comb begin
         word = '0;
         for (int k = 0; k < NUM_SEM; k++) begin
            if (in_rng[p] && (int'(idx[p]) == k) && held[k]) begin
               word = (DW'(1) << sem_pkg::LOCK_BIT) | (DW'(owner[k]) << ID_LSB);
            end
         end
      end
      assign bus_rdata[p*DW +: DW] = word;

      a_r7_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(bus_addr[p*ADDR_W+2 +: IW]) >= NUM_SEM) |-> (bus_rdata[p*DW +: DW] == '0));
      a_r9_undefined_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
         ((bus_rdata[p*DW +: DW] & ~LIVE_MASK) == '0));
   end

   for (genvar k = 0; k < NUM_SEM; k++) begin : g_sem
      logic [NUM_PORTS-1:0] hit_k;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_t
         assign hit_k[p] = hit_pk[p][k];
      end
      sem_cell #(.NUM_PORTS(NUM_PORTS), .ID_W(ID_W)) i_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (hit_k),
         .lock  (lock_v),
         .id    (id_v),
         .held  (held[k]),
         .owner (owner[k])
      );
   end
endmodule

// File: tb/test_sem_bank.sv
module test_sem_bank;
   localparam int NS = 32, NP = 2, AW = 10;
   logic clk = 0, rst_n = 0;
   logic [NP-1:0]    we = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*32-1:0] wdata = '0;
   logic [NP*32-1:0] rdata;
   int total = 0, bad = 0;
   bit m_held [NS];
   int m_own  [NS];

   always #5 clk = ~clk;

   sem_bank i_sem_bank (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
                        .bus_wdata(wdata), .bus_rdata(rdata));

   function automatic logic [31:0] lockw(int id); return 32'h8000_0000 | (32'(id & 15) << 8); endfunction
   function automatic logic [31:0] relw(int id);  return 32'(id & 15) << 8; endfunction

   function automatic logic [31:0] model_rd(logic [AW-1:0] a);
      int k = int'(a[AW-1:2]);
      if (k >= NS || !m_held[k]) return 32'h0;
      return lockw(m_own[k]);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic put(int p, bit w, int a, logic [31:0] d);
      we[p] = w; addr[p*AW +: AW] = AW'(a); wdata[p*32 +: 32] = d;
   endtask

   task automatic idle(); we = '0; endtask

   // compare every port against the model, then advance one clock
   task automatic step(string tag);
      #1;
      for (int p = 0; p < NP; p++) chk(tag, rdata[p*32 +: 32], model_rd(addr[p*AW +: AW]));
      @(posedge clk);
      for (int k = 0; k < NS; k++) begin
         if (m_held[k]) begin
            for (int p = 0; p < NP; p++)
               if (we[p] && int'(addr[p*AW+2 +: AW-2]) == k && !wdata[p*32+31]
                   && int'(wdata[p*32+8 +: 4]) == m_own[k]) begin
                  m_held[k] = 0; m_own[k] = 0;
               end
         end else begin
            for (int p = NP-1; p >= 0; p--)
               if (we[p] && int'(addr[p*AW+2 +: AW-2]) == k && wdata[p*32+31]) begin
                  m_held[k] = 1; m_own[k] = int'(wdata[p*32+8 +: 4]);
               end
         end
      end
      @(negedge clk);
   endtask

   task automatic rd(string tag, int a0, int a1, logic [31:0] e0, logic [31:0] e1);
      idle(); put(0, 0, a0, 0); put(1, 0, a1, 0);
      #1;
      chk(tag, rdata[31:0], e0);
      chk(tag, rdata[63:32], e1);
      step(tag);
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NS; k++) begin m_held[k] = 0; m_own[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd("R1", 0, 'h7C, 0, 0);
      // R2 take free semaphore 3
      idle(); put(0, 1, 12, lockw(1)); step("R2");
      rd("R2", 12, 12, 32'h8000_0100, 32'h8000_0100);
      // R3 foreign lock ignored
      idle(); put(1, 1, 12, lockw(2)); step("R3");
      rd("R3", 12, 12, 32'h8000_0100, 32'h8000_0100);
      // R5 foreign release ignored
      idle(); put(1, 1, 12, relw(2)); step("R5");
      rd("R5", 12, 12, 32'h8000_0100, 32'h8000_0100);
      // R10 owner relock keeps it
      idle(); put(0, 1, 12, lockw(1)); step("R10");
      rd("R10", 12, 0, 32'h8000_0100, 0);
      // R4 owner release
      idle(); put(1, 1, 12, relw(1)); step("R4");
      rd("R4", 12, 12, 0, 0);
      // R6 contention on semaphore 5
      idle(); put(0, 1, 20, lockw(3)); put(1, 1, 20, lockw(4)); step("R6");
      rd("R6", 20, 20, 32'h8000_0300, 32'h8000_0300);
      // R7 out of range writes and reads
      idle(); put(0, 1, 'h80, lockw(6)); put(1, 1, 'h3FC, lockw(6)); step("R7");
      rd("R7", 'h80, 'h3FC, 0, 0);
      rd("R7", 0, 'h7C, 0, 0);
      // R8 independence; both ports on different words
      idle(); put(0, 1, 0, lockw(7)); put(1, 1, 4, lockw(8)); step("R8");
      rd("R8", 0, 4, 32'h8000_0700, 32'h8000_0800);
      rd("R8", 8, 20, 0, 32'h8000_0300);
      // R9 garbage bits in lock word
      idle(); put(1, 1, 36, 32'hFFFF_FAFF); step("R9");
      rd("R9", 36, 36, 32'h8000_0A00, 32'h8000_0A00);
      // randomized phase compared against the model every clock
      for (int n = 0; n < 600; n++) begin
         for (int p = 0; p < NP; p++) begin
            int a = ($urandom_range(0, 9) == 0) ? 4 * $urandom_range(32, 255) : 4 * $urandom_range(0, 3);
            int id = $urandom_range(0, 3);
            logic [31:0] d = $urandom_range(0, 1) ? lockw(id) : relw(id);
            put(p, $urandom_range(0, 2) != 0, a, d);
         end
         step("R2_R6_random");
      end
      idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule